// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a host a two-address window into a byte-wide configuration space. One address takes a register number (the index), the next address up moves the value of that register in or out. A board strap picks one of two base addresses for the pair. Accesses that miss the selected pair are ignored.

Until a key is written, the space stays shut: the host must write the enter key to the index address on two back-to-back accesses to the pair. Writing the exit key to the index address shuts the space again. While shut, data reads return all ones and data writes change nothing. Once open, register numbers below a local threshold reach a small global bank: a device-select register, read-only identity and revision values, and a strap status bit. Numbers at or above the threshold go out on a register-file interface, together with the selected device number, to whichever downstream device is banked in.

Top module: `sio_cfg_port`

## Requirements
- R1: The index address is the selected base (0x2E when `base_sel` is 0, 0x4E when it is 1) and the data address is base plus 1. Writes to any other address have no effect, reads of any other address return 0xFF, and an index-port read in the open state returns the current index.
- R2: The space opens only after the enter key 0x87 is written to the index address on two consecutive writes to the port pair.
- R3: While not open, an index write of any value other than 0x87, or a data-port write between the two key writes, restarts the key sequence.
- R4: An index write of the exit key 0xAA while open closes the space; that write does not change the index.
- R5: While closed, every read of the index or data address returns 0xFF.
- R6: While closed, data-port writes change no register and raise no downstream write strobe.
- R7: Global register 0x07 holds the device select; it reads back through the data port, drives the `ldn` output and resets to 0x00.
- R8: Global registers 0x20 and 0x21 return the parameter identity and revision bytes and ignore writes.
- R9: Global register 0x26 returns the strap in bit 6 (0 for base 0x2E, 1 for base 0x4E) with all other bits 0.
- R10: An index at or above 0x30 is forwarded: a data write pulses `ld_wr` with the index and data for one cycle, a data read pulses `ld_rd` and returns `ld_rdata`.
- R11: Global register numbers below 0x30 other than 0x07, 0x20, 0x21 and 0x26 read 0xFF and ignore writes.
- R12: After reset the space is closed and the device select is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Strap: 0 selects base 0x2E, 1 selects base 0x4E |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_rdata | output | 8 | I/O read data, valid in the cycle of `io_rd` |
| ldn | output | 8 | Selected logical device number |
| ld_idx | output | 8 | Register number for the downstream device |
| ld_wdata | output | 8 | Write data for the downstream device |
| ld_wr | output | 1 | Downstream write strobe |
| ld_rd | output | 1 | Downstream read strobe |
| ld_rdata | input | 8 | Downstream read data, combinational from `ld_idx` |

## Verification
The bench builds the block with the default addresses, keys and 0x30 threshold, but with identity 0xB4 and revision 0x73 so that those reads cannot be confused with reset zeros or the 0xFF idle value. Because `base_sel` is a port, one build reaches both bases: the strap is flipped mid-run, which brings the R9 status bit and the off-base R1 cases into both states. The downstream device is modelled as `ld_rdata = ld_idx ^ 0x3C`, which gives every forwarded read a distinct expected value.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode #(
  parameter int unsigned        ADDR_W = 16,
  parameter logic [ADDR_W-1:0]  BASE_A = 16'h002E,
  parameter logic [ADDR_W-1:0]  BASE_B = 16'h004E
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              base_sel,
  output logic              hit_idx,
  output logic              hit_dat
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base    = base_sel ? BASE_B : BASE_A;
    hit_idx = (io_addr == base);
    hit_dat = (io_addr == (base + ADDR_W'(1)));
  end
endmodule

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] ENTER_KEY = 8'h87,
  parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       idx_load
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      KEY_IDLE: if (idx_wr && wdata == ENTER_KEY) state_d = KEY_HALF;
      KEY_HALF: begin
        if (idx_wr && wdata == ENTER_KEY) state_d = KEY_OPEN;
        else if (idx_wr || dat_wr)        state_d = KEY_IDLE;
      end
      KEY_OPEN: if (idx_wr && wdata == EXIT_KEY) state_d = KEY_IDLE;
      default:  state_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end

  assign cfg_open = (state_q == KEY_OPEN);
  assign idx_load = cfg_open && idx_wr && (wdata != EXIT_KEY);
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs #(
  parameter logic [7:0] DEV_ID      = 8'h00,
  parameter logic [7:0] DEV_REV     = 8'h00,
  parameter logic [7:0] LOCAL_START = 8'h30,
  parameter logic [7:0] SEL_IDX     = 8'h07,
  parameter logic [7:0] ID_IDX      = 8'h20,
  parameter logic [7:0] REV_IDX     = 8'h21,
  parameter logic [7:0] STRAP_IDX   = 8'h26,
  parameter int unsigned STRAP_BIT  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] index,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       base_sel,
  output logic [7:0] ldn,
  output logic [7:0] rdata,
  output logic       is_local
);
  logic [7:0] ldn_q;
  logic       ldn_we;
  logic [7:0] strap_byte;

  assign is_local = (index >= LOCAL_START);
  assign ldn_we   = wr_en && (index == SEL_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ldn_q <= 8'h00;
    else if (ldn_we) ldn_q <= wdata;
  end

  always_comb begin
    strap_byte            = 8'h00;
    strap_byte[STRAP_BIT] = base_sel;
    case (index)
      SEL_IDX:   rdata = ldn_q;
      ID_IDX:    rdata = DEV_ID;
      REV_IDX:   rdata = DEV_REV;
      STRAP_IDX: rdata = strap_byte;
      default:   rdata = 8'hFF;
    endcase
  end

  assign ldn = ldn_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_A      = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_B      = 16'h004E,
  parameter logic [7:0]        ENTER_KEY   = 8'h87,
  parameter logic [7:0]        EXIT_KEY    = 8'hAA,
  parameter logic [7:0]        DEV_ID      = 8'hB4,
  parameter logic [7:0]        DEV_REV     = 8'h73,
  parameter logic [7:0]        LOCAL_START = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic [7:0]        ldn,
  output logic [7:0]        ld_idx,
  output logic [7:0]        ld_wdata,
  output logic              ld_wr,
  output logic              ld_rd,
  input  logic [7:0]        ld_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  logic       hit_idx, hit_dat;
  logic       idx_wr, dat_wr;
  logic       cfg_open, idx_load, cfg_wr, is_local;
  logic [7:0] idx_q;
  logic [7:0] glb_rdata;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  sio_addr_decode #(.ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B)) u_dec (
    .io_addr (io_addr),
    .base_sel(base_sel),
    .hit_idx (hit_idx),
    .hit_dat (hit_dat)
  );

  assign idx_wr = io_wr && hit_idx;
  assign dat_wr = io_wr && hit_dat;

  sio_unlock_fsm #(.ENTER_KEY(ENTER_KEY), .EXIT_KEY(EXIT_KEY)) u_key (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .idx_wr  (idx_wr),
    .dat_wr  (dat_wr),
    .wdata   (io_wdata),
    .cfg_open(cfg_open),
    .idx_load(idx_load)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      idx_q <= 8'h00;
    else if (idx_load) idx_q <= io_wdata;
  end

  assign cfg_wr = dat_wr && cfg_open;

  sio_global_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .LOCAL_START(LOCAL_START)) u_glb (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .index   (idx_q),
    .wr_en   (cfg_wr && !is_local),
    .wdata   (io_wdata),
    .base_sel(base_sel),
    .ldn     (ldn),
    .rdata   (glb_rdata),
    .is_local(is_local)
  );

  assign ld_idx   = idx_q;
  assign ld_wdata = io_wdata;
  assign ld_wr    = cfg_wr && is_local;
  assign ld_rd    = io_rd && hit_dat && cfg_open && is_local;

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && cfg_open) begin
      if (hit_idx)      io_rdata = idx_q;
      else if (hit_dat) io_rdata = is_local ? ld_rdata : glb_rdata;
    end
  end
endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_A      = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_B      = 16'h004E,
  parameter logic [7:0]        ENTER_KEY   = 8'h87,
  parameter logic [7:0]        EXIT_KEY    = 8'hAA,
  parameter logic [7:0]        LOCAL_START = 8'h30
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              base_sel,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic [7:0]        ldn,
  input logic [7:0]        ld_idx,
  input logic              ld_wr,
  input logic              cfg_open
);
  logic chk_idx_hit;
  assign chk_idx_hit = (io_addr == (base_sel ? BASE_B : BASE_A));

  assert_open_needs_keys_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(cfg_open) |-> $past(io_wr && io_wdata == ENTER_KEY));

  assert_exit_closes_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_open && io_wr && chk_idx_hit && io_wdata == EXIT_KEY) |=> !cfg_open);

  assert_closed_reads_ff_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (io_rd && !cfg_open) |-> io_rdata == 8'hFF);

  assert_no_fwd_when_closed_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_wr |-> cfg_open);

  assert_ldn_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$past(io_wr) |-> $stable(ldn));

  assert_fwd_range_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_wr |-> ld_idx >= LOCAL_START);

  always_ff @(posedge clk) begin
    if (!rst_q_n) begin
      assert_reset_state_R12: assert (ldn == 8'h00 && !cfg_open);
    end
  end
endmodule

bind sio_cfg_port sio_cfg_checker #(
  .ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B),
  .ENTER_KEY(ENTER_KEY), .EXIT_KEY(EXIT_KEY), .LOCAL_START(LOCAL_START)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .base_sel(base_sel), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
  .ldn(ldn), .ld_idx(ld_idx), .ld_wr(ld_wr), .cfg_open(cfg_open)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_sel;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr, io_rd;
  logic [7:0]  io_rdata, ldn, ld_idx, ld_wdata, ld_rdata;
  logic        ld_wr, ld_rd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  int ld_wr_cnt = 0;
  int ld_rd_cnt = 0;
  logic [7:0] last_wr_idx, last_wr_dat;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // downstream device model
  assign ld_rdata = ld_idx ^ 8'h3C;

  sio_cfg_port #(.DEV_ID(8'hB4), .DEV_REV(8'h73)) u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .ldn(ldn), .ld_idx(ld_idx), .ld_wdata(ld_wdata), .ld_wr(ld_wr),
    .ld_rd(ld_rd), .ld_rdata(ld_rdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data and downstream strobes, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && io_rd) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", io_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(io_rdata == e, t, io_rdata, e);
      end
    end
    if (rst_n && ld_wr) begin
      ld_wr_cnt++;
      last_wr_idx = ld_idx;
      last_wr_dat = ld_wdata;
    end
    if (rst_n && ld_rd) ld_rd_cnt++;
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; base_sel = 1'b0; io_addr = '0; io_wdata = '0;
    io_wr = 1'b0; io_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R12 reset state
    check(ldn == 8'h00, "R12 ldn after reset", ldn, 0);
    rd(16'h002F, 8'hFF, "R12 R5 closed data read");
    rd(16'h002E, 8'hFF, "R5 closed index read");

    // R6 closed data writes ignored
    wr(16'h002E, 8'h07);
    wr(16'h002F, 8'h05);
    wr(16'h002E, 8'h30);
    wr(16'h002F, 8'h66);
    check(ldn == 8'h00, "R6 ldn unchanged", ldn, 0);
    check(ld_wr_cnt == 0, "R6 no ld_wr", ld_wr_cnt, 0);

    // R3 broken sequences
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h11); wr(16'h002E, 8'h87);
    rd(16'h002F, 8'hFF, "R3 other value between keys");
    wr(16'h002F, 8'h00); wr(16'h002E, 8'h87);
    rd(16'h002F, 8'hFF, "R3 data write between keys");
    wr(16'h002E, 8'h55);
    rd(16'h002F, 8'hFF, "R3 still closed");

    // R2 open; R8 identity
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    wr(16'h002E, 8'h20);
    rd(16'h002F, 8'hB4, "R2 R8 device id");
    wr(16'h002E, 8'h21);
    rd(16'h002F, 8'h73, "R8 revision");
    wr(16'h002F, 8'h00);
    rd(16'h002F, 8'h73, "R8 revision read-only");
    rd(16'h002E, 8'h21, "R1 index readback");

    // R9 strap 0
    wr(16'h002E, 8'h26);
    rd(16'h002F, 8'h00, "R9 strap low");

    // R7 device select
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h08);
    check(ldn == 8'h08, "R7 ldn output", ldn, 8'h08);
    rd(16'h002F, 8'h08, "R7 select readback");

    // R11 unimplemented global
    wr(16'h002E, 8'h15);
    rd(16'h002F, 8'hFF, "R11 hole reads ff");
    wr(16'h002F, 8'h33);
    check(ldn == 8'h08, "R11 write no effect", ldn, 8'h08);

    // R10 forwarding
    wr(16'h002E, 8'h30); wr(16'h002F, 8'hA5);
    check(ld_wr_cnt == 1, "R10 ld_wr count", ld_wr_cnt, 1);
    check(last_wr_idx == 8'h30 && last_wr_dat == 8'hA5, "R10 ld_wr payload",
          {last_wr_idx, last_wr_dat}, 16'h30A5);
    rd(16'h002F, 8'h30 ^ 8'h3C, "R10 forwarded read 0x30");
    wr(16'h002E, 8'hF7);
    rd(16'h002F, 8'hF7 ^ 8'h3C, "R10 forwarded read 0xF7");
    check(ld_rd_cnt == 2, "R10 ld_rd count", ld_rd_cnt, 2);

    // R1 other base ignored
    wr(16'h004E, 8'h07);
    rd(16'h002E, 8'hF7, "R1 off-base write ignored");
    rd(16'h004F, 8'hFF, "R1 off-base read ff");

    // R4 exit
    wr(16'h002E, 8'hAA);
    rd(16'h002F, 8'hFF, "R4 closed after exit");
    check(ldn == 8'h08, "R4 select kept", ldn, 8'h08);

    // R1 R9 strap high
    base_sel = 1'b1;
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    rd(16'h004E, 8'hF7, "R4 exit key did not load index");
    wr(16'h004E, 8'h26);
    rd(16'h004F, 8'h40, "R9 strap high");
    rd(16'h002F, 8'hFF, "R1 old base ignored");
    wr(16'h004E, 8'h07); wr(16'h004F, 8'h03);
    check(ldn == 8'h03, "R1 R7 select via high base", ldn, 8'h03);
    wr(16'h004E, 8'hAA);
    rd(16'h004F, 8'hFF, "R4 closed at high base");

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule